// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block carries register writes from a fast bus clock into registers that live in a slow 32.768 kHz always-on domain. It takes one write at a time. Address and data are held on the bus side while a toggle handshake crosses into the slow clock. The write is committed there on the fourth slow rising edge after it was accepted, and the completion toggle comes back through a two-flop synchronizer.

Software follows progress through four status flags: busy, ready for the next write, complete and error. The complete flag clears itself when status is read. A write that arrives while another is still in flight is dropped and raises the error flag. The error flag is cleared by writing a one to it, and that clearing write also goes through the slow-domain commit.

The interrupt-enable register is not synchronized. It is written at bus speed and takes effect at once. One interrupt line combines every flag with its own enable.

Top module: `lp_write_sync`

## Requirements
- R1: After reset, `stat_o` equals 0x200: ready flag (bit 9) set; busy (bit 10), complete (bit 8) and error (bit 7) clear. `irq_o` and `lp_we` are low and all interrupt enables are zero.
- R2: When a request arrives while the busy flag is clear, it is accepted. On the next bus cycle busy is set and ready is clear.
- R3: An accepted write appears exactly once in the slow domain. `lp_we` is high for one slow cycle, starting at the third slow rising edge after acceptance, and carries the accepted address and data, so the target register takes it on the fourth edge.
- R4: Busy stays set and complete stays clear until the fourth slow rising edge after acceptance. Within three bus cycles after that edge, busy is clear, ready is set and complete is set.
- R5: A status read (`stat_rd`) clears the complete flag on the next bus edge and leaves the other flags as they were.
- R6: A request that arrives while busy is set is dropped: it produces no slow-domain write and does not disturb the held write. The error flag (bit 7) is set and stays set through the completion of the write in flight.
- R7: The error flag clears only when a write to the status address (parameter `STAT_ADDR`, default 5) with data bit 7 set has completed through the synchronizer. It stays set while that write is still in flight.
- R8: A write to the status address with data bit 7 clear completes normally and leaves the error flag unchanged.
- R9: A write to the interrupt-enable register takes effect on the next bus edge and keeps only bits 10 to 7. It does not set busy or complete and produces no slow-domain write.
- R10: `irq_o` is high exactly when, for at least one of bits 10 to 7, the status flag and the enable bit at that same position are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lp_clk | input | 1 | Slow 32.768 kHz domain clock |
| req_valid | input | 1 | Request to write a slow-domain register |
| req_addr | input | AW | Register address of the request |
| req_data | input | DW | Data of the request |
| ien_we | input | 1 | Write strobe for the interrupt-enable register |
| ien_wdata | input | 11 | New interrupt-enable value (bits 10..7 kept) |
| stat_rd | input | 1 | Status read strobe; clears the complete flag |
| stat_o | output | 11 | Status view: bit 10 busy, 9 ready, 8 complete, 7 error |
| irq_o | output | 1 | Interrupt request |
| lp_we | output | 1 | Slow-domain write strobe, one slow cycle |
| lp_addr | output | AW | Slow-domain write address |
| lp_data | output | DW | Slow-domain write data |

## Verification
The assertions assume that every bus-side strobe is synchronous to `clk`. They also assume that `lp_clk` is slower than the bus clock by a wide margin, so the returning toggle has settled well before the next slow edge. They further assume that the held address and data, which cross as quasi-static buses, do not change while busy is set. The bench changes inputs only on the falling edge of the bus clock and runs the slow clock at 32 bus cycles per period. It also places the slow edges a quarter of a bus period away from every bus edge, so the slow edge on which acceptance falls is never ambiguous.

// File: rtl/lpws_pkg.sv
package lpws_pkg;
  localparam int STAT_W  = 11;
  localparam int WBF_BIT = 10;
  localparam int WNF_BIT = 9;
  localparam int WCF_BIT = 8;
  localparam int WEF_BIT = 7;
  localparam logic [STAT_W-1:0] EN_MASK = STAT_W'((1 << WBF_BIT) | (1 << WNF_BIT) |
                                                  (1 << WCF_BIT) | (1 << WEF_BIT));
endpackage

// File: rtl/lpws_rst_sync.sv
module lpws_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/lpws_sync.sv
module lpws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  assign stg_d = {stg_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpws_bus_ctl.sv
module lpws_bus_ctl
  import lpws_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 32,
  parameter int STAT_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              ien_we,
  input  logic [STAT_W-1:0] ien_wdata,
  input  logic              stat_rd,
  input  logic              ack_lvl,
  output logic              req_tgl,
  output logic [AW-1:0]     hold_addr,
  output logic [DW-1:0]     hold_data,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] ien_o,
  output logic              irq_o
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  logic              busy_q, busy_d;
  logic              wcf_q, wcf_d;
  logic              wef_q, wef_d;
  logic              tgl_q, tgl_d;
  logic              seen_q;
  logic [STAT_W-1:0] ien_q, ien_d;
  logic [AW-1:0]     haddr_q;
  logic [DW-1:0]     hdata_q;
  logic              accept, overlap, done, clr_err;

  always_comb begin
    accept  = req_valid & ~busy_q;
    overlap = req_valid &  busy_q;
    done    = ack_lvl ^ seen_q;
    clr_err = done & (haddr_q == STAT_A) & hdata_q[WEF_BIT];

    busy_d = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;

    tgl_d = tgl_q ^ accept;

    wcf_d = wcf_q;
    if (done)         wcf_d = 1'b1;
    else if (stat_rd) wcf_d = 1'b0;

    wef_d = wef_q;
    if (overlap)      wef_d = 1'b1;
    else if (clr_err) wef_d = 1'b0;

    ien_d = ien_we ? (ien_wdata & EN_MASK) : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wcf_q  <= 1'b0;
      wef_q  <= 1'b0;
      tgl_q  <= 1'b0;
      seen_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wcf_q  <= wcf_d;
      wef_q  <= wef_d;
      tgl_q  <= tgl_d;
      seen_q <= ack_lvl;
      ien_q  <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q <= '0;
      hdata_q <= '0;
    end else if (accept) begin
      haddr_q <= req_addr;
      hdata_q <= req_data;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[WBF_BIT] = busy_q;
    stat_o[WNF_BIT] = ~busy_q;
    stat_o[WCF_BIT] = wcf_q;
    stat_o[WEF_BIT] = wef_q;
  end

  assign irq_o     = |(stat_o & ien_q);
  assign ien_o     = ien_q;
  assign req_tgl   = tgl_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;
endmodule

// File: rtl/lpws_lp_commit.sv
module lpws_lp_commit #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          lp_clk,
  input  logic          rst_n,
  input  logic          req_lvl,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  output logic          lp_we,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data,
  output logic          ack_tgl
);
  logic          seen_q, we_q, ack_q;
  logic          fresh;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign fresh = req_lvl ^ seen_q;

  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      we_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      seen_q <= req_lvl;
      we_q   <= fresh;
      ack_q  <= ack_q ^ we_q;
    end
  end

  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fresh) begin
      addr_q <= hold_addr;
      data_q <= hold_data;
    end
  end

  assign lp_we   = we_q;
  assign lp_addr = addr_q;
  assign lp_data = data_q;
  assign ack_tgl = ack_q;
endmodule

// File: rtl/lp_write_sync.sv
module lp_write_sync
  import lpws_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 32,
  parameter int STAT_ADDR = 5,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_clk,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              ien_we,
  input  logic [STAT_W-1:0] ien_wdata,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o,
  output logic              lp_we,
  output logic [AW-1:0]     lp_addr,
  output logic [DW-1:0]     lp_data
);
  logic              brst_n, lrst_n;
  logic              req_tgl, req_lvl, ack_tgl, ack_lvl;
  logic [AW-1:0]     hold_addr;
  logic [DW-1:0]     hold_data;
  logic [STAT_W-1:0] ien_q;

  lpws_rst_sync u_brst (.clk(clk),    .arst_n(rst_n), .rst_n_o(brst_n));
  lpws_rst_sync u_lrst (.clk(lp_clk), .arst_n(rst_n), .rst_n_o(lrst_n));

  lpws_bus_ctl #(.AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)) u_bus (
    .clk(clk), .rst_n(brst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .stat_rd(stat_rd),
    .ack_lvl(ack_lvl), .req_tgl(req_tgl),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .stat_o(stat_o), .ien_o(ien_q), .irq_o(irq_o)
  );

  lpws_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(lp_clk), .rst_n(lrst_n), .d(req_tgl), .q(req_lvl)
  );

  lpws_lp_commit #(.AW(AW), .DW(DW)) u_lp (
    .lp_clk(lp_clk), .rst_n(lrst_n), .req_lvl(req_lvl),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data), .ack_tgl(ack_tgl)
  );

  lpws_sync #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk(clk), .rst_n(brst_n), .d(ack_tgl), .q(ack_lvl)
  );
endmodule

// File: rtl/lpws_chk.sv
module lpws_chk
  import lpws_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              lp_clk,
  input logic              brst_n,
  input logic              lrst_n,
  input logic              req_valid,
  input logic              stat_rd,
  input logic              ien_we,
  input logic [STAT_W-1:0] ien_wdata,
  input logic [STAT_W-1:0] stat_o,
  input logic [STAT_W-1:0] ien_q,
  input logic              irq_o,
  input logic              lp_we,
  input logic [DW-1:0]     hold_data
);
  // R2
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!brst_n)
    (req_valid && stat_o[WNF_BIT]) |=> (stat_o[WBF_BIT] && !stat_o[WNF_BIT]));

  // R6
  overlap_err_chk: assert property (@(posedge clk) disable iff (!brst_n)
    (req_valid && stat_o[WBF_BIT]) |=> (stat_o[WEF_BIT] && $stable(hold_data)));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!brst_n)
    (stat_rd && !stat_o[WBF_BIT]) |=> !stat_o[WCF_BIT]);

  // R4
  done_flags_chk: assert property (@(posedge clk) disable iff (!brst_n)
    $fell(stat_o[WBF_BIT]) |-> (stat_o[WCF_BIT] && stat_o[WNF_BIT]));

  // R9
  ien_direct_chk: assert property (@(posedge clk) disable iff (!brst_n)
    ien_we |=> (ien_q == ($past(ien_wdata) & EN_MASK)));

  // R10
  irq_complete_chk: assert property (@(posedge clk) disable iff (!brst_n)
    (stat_o[WCF_BIT] && ien_q[WCF_BIT]) |-> irq_o);

  // R3
  lp_pulse_chk: assert property (@(posedge lp_clk) disable iff (!lrst_n)
    lp_we |=> !lp_we);
endmodule

bind lp_write_sync lpws_chk #(.DW(DW)) u_chk (
  .clk(clk), .lp_clk(lp_clk), .brst_n(brst_n), .lrst_n(lrst_n),
  .req_valid(req_valid), .stat_rd(stat_rd), .ien_we(ien_we),
  .ien_wdata(ien_wdata), .stat_o(stat_o), .ien_q(ien_q), .irq_o(irq_o),
  .lp_we(lp_we), .hold_data(hold_data)
);

// File: tb/lp_write_sync_bench.sv
`timescale 1ns/1ps
module lp_write_sync_bench;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] SA = 6'd5;
  localparam logic [10:0] M_WBF = 11'h400, M_WNF = 11'h200, M_WCF = 11'h100, M_WEF = 11'h080;

  logic          clk, rst_n, lp_clk;
  logic          req_valid, ien_we, stat_rd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [10:0]   ien_wdata, stat_o;
  logic          irq_o, lp_we;
  logic [AW-1:0] lp_addr;
  logic [DW-1:0] lp_data;

  int checks = 0;
  int errors = 0;
  int lp_edges = 0;
  int we_cnt = 0;
  logic [DW-1:0] last_data;

  lp_write_sync u_lp_write_sync (
    .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .stat_rd(stat_rd),
    .stat_o(stat_o), .irq_o(irq_o),
    .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data)
  );

  initial begin clk = 1'b0; forever #2.5 clk = ~clk; end
  initial begin lp_clk = 1'b0; #1.25; forever #80 lp_clk = ~lp_clk; end

  always @(posedge lp_clk) lp_edges = lp_edges + 1;
  always @(negedge lp_clk) if (lp_we === 1'b1) begin
    we_cnt = we_cnt + 1;
    last_data = lp_data;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int e0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(posedge clk);
    e0 = lp_edges;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int e0);
    wait (lp_edges >= e0 + 4);
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic set_ien(input logic [10:0] v);
    @(negedge clk); ien_we = 1'b1; ien_wdata = v;
    @(negedge clk); ien_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(stat_o), 32'h200);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 lp_we", 32'(lp_we), 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] pat [2];
    pat[0] = 32'hA5A5_0001;
    pat[1] = 32'h0F0F_F0F0;
    for (int i = 0; i < 2; i++) begin
      int e0;
      int c0;
      rd_status();
      c0 = we_cnt;
      do_write(AW'(i + 2), pat[i], e0);
      chk("R2 busy set", 32'(stat_o & (M_WBF | M_WNF)), 32'(M_WBF));
      wait (lp_edges == e0 + 3);
      @(negedge lp_clk);
      chk("R3 lp_we at edge 3", 32'(lp_we), 1);
      chk("R3 lp_addr", 32'(lp_addr), i + 2);
      chk("R3 lp_data", lp_data, pat[i]);
      chk("R4 busy before edge 4", 32'(stat_o & (M_WBF | M_WCF)), 32'(M_WBF));
      wait_done(e0);
      chk("R4 done flags", 32'(stat_o & (M_WBF | M_WNF | M_WCF)), 32'(M_WNF | M_WCF));
      chk("R3 single pulse", we_cnt, c0 + 1);
    end
  endtask

  task automatic t_read_clear();
    chk("R5 complete before read", 32'(stat_o), 32'(M_WNF | M_WCF));
    rd_status();
    chk("R5 complete cleared", 32'(stat_o), 32'(M_WNF));
  endtask

  task automatic t_ien_irq();
    int e0;
    int c0;
    set_ien(M_WCF);
    chk("R10 irq idle no complete", 32'(irq_o), 0);
    do_write(6'd1, 32'h1111_2222, e0);
    wait_done(e0);
    chk("R10 irq on complete", 32'(irq_o), 1);
    rd_status();
    chk("R10 irq after read", 32'(irq_o), 0);
    c0 = we_cnt;
    @(negedge clk); ien_we = 1'b1; ien_wdata = 11'h7FF;
    @(negedge clk); ien_we = 1'b0; ien_wdata = M_WNF;
    chk("R9 enable at bus speed", 32'(irq_o), 1);
    set_ien(M_WNF);
    repeat (6) @(posedge lp_clk);
    @(negedge clk);
    chk("R9 no write side effects", 32'(stat_o), 32'(M_WNF));
    chk("R9 no slow write", we_cnt, c0);
    do_write(6'd1, 32'h3333_4444, e0);
    chk("R10 ready enable while busy", 32'(irq_o), 0);
    set_ien(M_WBF);
    chk("R10 busy enable while busy", 32'(irq_o), 1);
    wait_done(e0);
    chk("R10 busy enable after done", 32'(irq_o), 0);
    rd_status();
    set_ien(11'h000);
  endtask

  task automatic t_overlap();
    int e0;
    int e1;
    int c0;
    set_ien(M_WEF);
    c0 = we_cnt;
    do_write(6'd3, 32'hAAAA_0003, e0);
    do_write(6'd4, 32'hBBBB_0004, e1);
    chk("R6 error set", 32'(stat_o & (M_WEF | M_WBF)), 32'(M_WEF | M_WBF));
    chk("R10 irq on error", 32'(irq_o), 1);
    wait_done(e0);
    chk("R6 one slow write", we_cnt, c0 + 1);
    chk("R6 first data kept", last_data, 32'hAAAA_0003);
    chk("R6 error persists", 32'(stat_o), 32'(M_WNF | M_WCF | M_WEF));
    rd_status();
  endtask

  task automatic t_err_clear();
    int e0;
    do_write(SA, 32'h0000_0100, e0);
    wait_done(e0);
    chk("R8 no clear without bit7", 32'(stat_o), 32'(M_WNF | M_WCF | M_WEF));
    rd_status();
    do_write(SA, 32'h0000_0080, e0);
    chk("R7 error held at accept", 32'(stat_o & M_WEF), 32'(M_WEF));
    wait (lp_edges == e0 + 3);
    @(negedge lp_clk);
    chk("R7 error held in flight", 32'(stat_o & M_WEF), 32'(M_WEF));
    wait_done(e0);
    chk("R7 error cleared on commit", 32'(stat_o), 32'(M_WNF | M_WCF));
    chk("R10 irq drops with error", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
    ien_we = 1'b0; ien_wdata = '0; stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge lp_clk);
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_read_clear();
    t_ien_irq();
    t_overlap();
    t_err_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule